// File: doc/BRIEF.md
# Load-Linked Reservation and Address Unit

This unit runs the load-linked doubleword operation of a 64-bit core. It takes one 32-bit instruction word at a time and decodes it in one of two incompatible layouts, picked by the `new_enc` input. The legacy layout carries a 16-bit signed displacement. The newer layout carries a 9-bit signed displacement and a function code. The unit adds the sign-extended displacement to the base register value to form the effective address, and checks that the address is aligned to eight bytes. If the checks pass, it issues one 64-bit read over a valid/ready request channel. When the read data is accepted on the response channel, it writes that data to the destination register.

The unit holds the single reservation of the processor: a link bit and the address that was reserved. A completed load-linked always sets the link bit and overwrites the address. The link bit is cleared when another agent stores to the reserved doubleword block, or when the store-conditional path pulses `sc_clear`. A load from another agent, including that agent's own load-linked, never clears it. The reservation lasts until it is cleared, so it may be left unused.

The controller has three states. S_IDLE accepts a word. On a clean load-linked it takes transition T_ACCEPT to S_REQ. S_REQ presents the request and takes T_GRANT to S_RSP when `mem_req_ready` is high. S_RSP waits for the response and takes T_DONE back to S_IDLE in the cycle the data is accepted. A word that raises an exception, or that is not a load-linked, leaves the unit in S_IDLE.

Top module: `ll_resv_unit`

## Requirements
- R1: With `new_enc`=0, a word with bits 31:26 = 110100 is a load-linked. Bits 25:21 select the base (`rs_idx`), bits 20:16 select rt, and bits 15:0 are a signed displacement. The request address is `base_val` plus the sign-extended displacement.
- R2: With `new_enc`=1, a word with bits 31:26 = 011111, bit 6 = 0 and bits 5:0 = 110111 is a load-linked. Its signed displacement is bits 15:7, sign-extended and added to `base_val`.
- R3: With `new_enc`=1, a word with bits 31:26 = 110100, or a newer-layout word with bit 6 = 1, raises `exc_valid` with `exc_code`=1 (reserved instruction). This code takes precedence over every other fault. No request is issued.
- R4: If the effective address has any of bits 2:0 nonzero, the unit raises `exc_code`=2 (address error). No request is issued, and the link bit and reserved address are unchanged.
- R5: An aligned, decoded load-linked presented with `xlate_fault`=1 raises `exc_code`=3. No request is issued, and the link bit and reserved address are unchanged.
- R6: A word that matches neither layout for the current mode is accepted with no exception (`exc_valid`=0) and has no effect.
- R7: A request stays valid with a stable address until `mem_req_ready` is seen, and it drops in the cycle after the grant.
- R8: In the cycle a response is accepted, `rf_we`=1, `rf_waddr`=rt and `rf_wdata`=`mem_rsp_data`. From the next cycle on, `link_bit`=1 and `link_addr` equals the effective address.
- R9: A new load-linked replaces the reserved address. After that, a store to the old block no longer clears the link bit.
- R10: A snooped store whose address matches `link_addr` in bits 63:3 clears the link bit. A snooped store to another block, or any snooped load, leaves it set.
- R11: `sc_clear` clears the link bit. If it arrives in the same cycle as a load-linked response, the set wins.
- R12: Once set, the link bit stays set for any number of cycles if nothing clears it.
- R13: `issue_ready` is 1 only in S_IDLE, so it is 0 from the cycle after T_ACCEPT until T_DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_enc | input | 1 | Selects the instruction layout: 1 = newer, 0 = legacy |
| issue_valid | input | 1 | Instruction word valid |
| issue_ready | output | 1 | Unit can accept a word (S_IDLE) |
| issue_insn | input | 32 | Instruction word |
| rs_idx | output | 5 | Base register index taken from the word |
| base_val | input | 64 | Value of the base register |
| xlate_fault | input | 1 | Translation fault for this access |
| exc_valid | output | 1 | Exception raised for the presented word |
| exc_code | output | 2 | 1 reserved, 2 alignment, 3 translation |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Unit waits for read data |
| mem_rsp_data | input | 64 | Read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index (rt) |
| rf_wdata | output | 64 | Register write data |
| snoop_valid | input | 1 | Access by another agent observed |
| snoop_is_store | input | 1 | The observed access is a store |
| snoop_addr | input | 64 | Address of the observed access |
| sc_clear | input | 1 | Clear strobe from the store-conditional path |
| link_bit | output | 1 | Reservation active |
| link_addr | output | 64 | Reserved address |

## Verification
The bench builds the unit with its default parameters: a 64-bit address width, a 5-bit register index and an alignment shift of 3. With these values it sweeps all 512 short displacements and a strided set of about 680 long displacements. The low bits of the base rotate through every residue, so each alignment case and sign extension is reached in both layouts. Fixed sequences then cover:
- reserved words and the priority between exception codes,
- translation faults,
- words that match neither layout,
- snooped loads and stores to the same and to other blocks,
- replacement of the reserved address,
- the same-cycle race between set and clear,
- a long idle wait with the reservation held.

// File: rtl/llr_pkg.sv
package llr_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_RSP  = 2'd2
    } llr_state_e;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_RSVD  = 2'd1,
        EXC_ALIGN = 2'd2,
        EXC_XLATE = 2'd3
    } llr_exc_e;

    localparam logic [5:0] OPC_LEGACY = 6'b110100;
    localparam logic [5:0] OPC_SPEC3  = 6'b011111;
    localparam logic [5:0] FN_LINKED  = 6'b110111;
endpackage

// File: rtl/llr_decode.sv
module llr_decode
    import llr_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int RIDX     = 5,
    parameter int ALIGN_LG = 3
) (
    input  logic [31:0]     insn,
    input  logic            new_enc,
    input  logic [XLEN-1:0] base_val,
    input  logic            xlate_fault,
    output logic [RIDX-1:0] base_idx,
    output logic [RIDX-1:0] dst_idx,
    output logic [XLEN-1:0] ea,
    output logic            go,
    output llr_exc_e        exc
);
    localparam int LONG_W  = 16;
    localparam int SHORT_W = 9;

    logic [XLEN-1:0] disp;
    logic            matched;
    logic            reserved;
    logic            misalign;

    assign base_idx = RIDX'(insn[25:21]);
    assign dst_idx  = RIDX'(insn[20:16]);

    always_comb begin
        disp     = '0;
        matched  = 1'b0;
        reserved = 1'b0;
        if (new_enc) begin
            if (insn[31:26] == OPC_SPEC3 && insn[5:0] == FN_LINKED) begin
                if (insn[6]) begin
                    reserved = 1'b1;
                end else begin
                    matched = 1'b1;
                    disp    = {{(XLEN-SHORT_W){insn[15]}}, insn[15:7]};
                end
            end else if (insn[31:26] == OPC_LEGACY) begin
                reserved = 1'b1;
            end
        end else if (insn[31:26] == OPC_LEGACY) begin
            matched = 1'b1;
            disp    = {{(XLEN-LONG_W){insn[15]}}, insn[15:0]};
        end
    end

    assign ea       = base_val + disp;
    assign misalign = |ea[ALIGN_LG-1:0];

    always_comb begin
        if (reserved)
            exc = EXC_RSVD;
        else if (matched && misalign)
            exc = EXC_ALIGN;
        else if (matched && xlate_fault)
            exc = EXC_XLATE;
        else
            exc = EXC_NONE;
    end

    assign go = matched && !misalign && !xlate_fault;
endmodule

// File: rtl/llr_ctrl.sv
module llr_ctrl
    import llr_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int RIDX     = 5,
    parameter int ALIGN_LG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            go,
    input  logic [XLEN-1:0] ea,
    input  logic [RIDX-1:0] dst_idx,
    output logic            issue_ready,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    output logic            mem_rsp_ready,
    output logic            rsp_take,
    output logic [RIDX-1:0] dst_q
);
    llr_state_e      state_q, state_d;
    logic [XLEN-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            dst_q  <= '0;
        end else if (state_q == S_IDLE && issue_valid && go) begin
            addr_q <= ea;
            dst_q  <= dst_idx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (issue_valid && go) state_d = S_REQ;
            S_REQ:   if (mem_req_ready)     state_d = S_RSP;
            S_RSP:   if (mem_rsp_valid)     state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        issue_ready   = 1'b0;
        mem_req_valid = 1'b0;
        mem_rsp_ready = 1'b0;
        rsp_take      = 1'b0;
        unique case (state_q)
            S_IDLE: issue_ready = 1'b1;
            S_REQ:  mem_req_valid = 1'b1;
            S_RSP: begin
                mem_rsp_ready = 1'b1;
                rsp_take      = mem_rsp_valid;
            end
            default: issue_ready = 1'b0;
        endcase
    end

    assign mem_req_addr = addr_q;

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    p_req_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[ALIGN_LG-1:0] == '0));

    p_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ready && issue_valid && go) |=> !issue_ready);
endmodule

// File: rtl/llr_link.sv
module llr_link #(
    parameter int XLEN     = 64,
    parameter int ALIGN_LG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set,
    input  logic [XLEN-1:0] set_addr,
    input  logic            snoop_valid,
    input  logic            snoop_is_store,
    input  logic [XLEN-1:0] snoop_addr,
    input  logic            sc_clear,
    output logic            link_bit,
    output logic [XLEN-1:0] link_addr
);
    logic [XLEN-1:0] diff;
    logic            same_blk;
    logic            kill;

    assign diff     = snoop_addr ^ link_addr;
    assign same_blk = ~|(diff >> ALIGN_LG);
    assign kill     = (snoop_valid && snoop_is_store && same_blk) || sc_clear;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_bit  <= 1'b0;
            link_addr <= '0;
        end else if (set) begin
            link_bit  <= 1'b1;
            link_addr <= set_addr;
        end else if (kill) begin
            link_bit  <= 1'b0;
        end
    end

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> (link_bit && link_addr == $past(set_addr)));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clear && !set) |=> !link_bit);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (link_bit && !set && !sc_clear && !(snoop_valid && snoop_is_store)) |=> link_bit);

    p_load_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_bit && snoop_valid && !snoop_is_store && !sc_clear) |=> link_bit);
endmodule

// File: rtl/ll_resv_unit.sv
module ll_resv_unit
    import llr_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int RIDX     = 5,
    parameter int ALIGN_LG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            new_enc,
    input  logic            issue_valid,
    output logic            issue_ready,
    input  logic [31:0]     issue_insn,
    output logic [RIDX-1:0] rs_idx,
    input  logic [XLEN-1:0] base_val,
    input  logic            xlate_fault,
    output logic            exc_valid,
    output logic [1:0]      exc_code,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    output logic            mem_rsp_ready,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic            rf_we,
    output logic [RIDX-1:0] rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    input  logic            snoop_valid,
    input  logic            snoop_is_store,
    input  logic [XLEN-1:0] snoop_addr,
    input  logic            sc_clear,
    output logic            link_bit,
    output logic [XLEN-1:0] link_addr
);
    logic [RIDX-1:0] dst_idx;
    logic [RIDX-1:0] dst_q;
    logic [XLEN-1:0] ea;
    logic            go;
    logic            rsp_take;
    llr_exc_e        exc;

    llr_decode #(.XLEN(XLEN), .RIDX(RIDX), .ALIGN_LG(ALIGN_LG)) u_dec (
        .insn        (issue_insn),
        .new_enc     (new_enc),
        .base_val    (base_val),
        .xlate_fault (xlate_fault),
        .base_idx    (rs_idx),
        .dst_idx     (dst_idx),
        .ea          (ea),
        .go          (go),
        .exc         (exc)
    );

    llr_ctrl #(.XLEN(XLEN), .RIDX(RIDX), .ALIGN_LG(ALIGN_LG)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_valid   (issue_valid),
        .go            (go),
        .ea            (ea),
        .dst_idx       (dst_idx),
        .issue_ready   (issue_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .rsp_take      (rsp_take),
        .dst_q         (dst_q)
    );

    llr_link #(.XLEN(XLEN), .ALIGN_LG(ALIGN_LG)) u_link (
        .clk            (clk),
        .rst_n          (rst_n),
        .set            (rsp_take),
        .set_addr       (mem_req_addr),
        .snoop_valid    (snoop_valid),
        .snoop_is_store (snoop_is_store),
        .snoop_addr     (snoop_addr),
        .sc_clear       (sc_clear),
        .link_bit       (link_bit),
        .link_addr      (link_addr)
    );

    assign exc_valid = issue_ready && issue_valid && (exc != EXC_NONE);
    assign exc_code  = exc_valid ? exc : EXC_NONE;
    assign rf_we     = rsp_take;
    assign rf_waddr  = dst_q;
    assign rf_wdata  = mem_rsp_data;

    p_exc_noreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !mem_req_valid);

    p_exc_keeps_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !sc_clear && !(snoop_valid && snoop_is_store))
            |=> ($stable(link_bit) && $stable(link_addr)));

    p_write_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> (link_bit && link_addr == $past(mem_req_addr)));
endmodule

// File: tb/sim_ll_resv_unit.sv
module sim_ll_resv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        new_enc = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [31:0] issue_insn = '0;
    logic [4:0]  rs_idx;
    logic [63:0] base_val = '0;
    logic        xlate_fault = 1'b0;
    logic        exc_valid;
    logic [1:0]  exc_code;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [63:0] mem_rsp_data = '0;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [63:0] rf_wdata;
    logic        snoop_valid = 1'b0;
    logic        snoop_is_store = 1'b0;
    logic [63:0] snoop_addr = '0;
    logic        sc_clear = 1'b0;
    logic        link_bit;
    logic [63:0] link_addr;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  clr_on_rsp = 1'b0;

    always #4 clk = ~clk;

    ll_resv_unit u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_long(input logic [4:0] b, input logic [4:0] t, input logic [15:0] d);
        return {6'b110100, b, t, d};
    endfunction

    function automatic logic [31:0] enc_short(input logic [4:0] b, input logic [4:0] t, input logic [8:0] d, input logic b6);
        return {6'b011111, b, t, d, b6, 6'b110111};
    endfunction

    task automatic run_ll(input logic [31:0] w, input logic [63:0] b, input bit flt, input bit r6,
                          input logic [1:0] exp_exc, input bit exp_go, input logic [63:0] exp_ea,
                          input logic [63:0] data, input bit stall, input string tag);
        logic        pre_bit;
        logic [63:0] pre_addr;
        @(negedge clk);
        new_enc = r6; issue_insn = w; base_val = b; xlate_fault = flt; issue_valid = 1'b1;
        pre_bit = link_bit; pre_addr = link_addr;
        #1;
        chk(issue_ready == 1'b1, tag, 64'(issue_ready), 64'd1);
        chk(rs_idx == w[25:21], "R1", 64'(rs_idx), 64'(w[25:21]));
        chk(exc_code == exp_exc, tag, 64'(exc_code), 64'(exp_exc));
        chk(exc_valid == (exp_exc != 2'd0), tag, 64'(exc_valid), 64'(exp_exc != 2'd0));
        @(negedge clk);
        issue_valid = 1'b0; xlate_fault = 1'b0;
        if (!exp_go) begin
            chk(mem_req_valid == 1'b0, tag, 64'(mem_req_valid), 64'd0);
            chk(link_bit == pre_bit, tag, 64'(link_bit), 64'(pre_bit));
            chk(link_addr == pre_addr, tag, link_addr, pre_addr);
            chk(issue_ready == 1'b1, "R13", 64'(issue_ready), 64'd1);
        end else begin
            chk(mem_req_valid == 1'b1, tag, 64'(mem_req_valid), 64'd1);
            chk(mem_req_addr == exp_ea, tag, mem_req_addr, exp_ea);
            chk(issue_ready == 1'b0, "R13", 64'(issue_ready), 64'd0);
            if (stall) begin
                @(negedge clk);
                chk(mem_req_valid == 1'b1, "R7", 64'(mem_req_valid), 64'd1);
                chk(mem_req_addr == exp_ea, "R7", mem_req_addr, exp_ea);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk(mem_req_valid == 1'b0, "R7", 64'(mem_req_valid), 64'd0);
            chk(mem_rsp_ready == 1'b1, "R8", 64'(mem_rsp_ready), 64'd1);
            chk(rf_we == 1'b0, "R8", 64'(rf_we), 64'd0);
            mem_rsp_data = data; mem_rsp_valid = 1'b1; sc_clear = clr_on_rsp;
            #1;
            chk(rf_we == 1'b1, "R8", 64'(rf_we), 64'd1);
            chk(rf_waddr == w[20:16], "R8", 64'(rf_waddr), 64'(w[20:16]));
            chk(rf_wdata == data, "R8", rf_wdata, data);
            @(negedge clk);
            mem_rsp_valid = 1'b0; sc_clear = 1'b0;
            chk(link_bit == 1'b1, "R8", 64'(link_bit), 64'd1);
            chk(link_addr == exp_ea, "R8", link_addr, exp_ea);
            chk(issue_ready == 1'b1, "R13", 64'(issue_ready), 64'd1);
        end
    endtask

    task automatic snoop(input logic [63:0] a, input bit st);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_is_store = st; snoop_addr = a;
        @(negedge clk);
        snoop_valid = 1'b0; snoop_is_store = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] b, ea, a1, a2;
        repeat (3) @(negedge clk);
        chk(link_bit == 1'b0, "R12", 64'(link_bit), 64'd0);
        chk(mem_req_valid == 1'b0, "R7", 64'(mem_req_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(issue_ready == 1'b1, "R13", 64'(issue_ready), 64'd1);

        // R2 sweep: every 9-bit displacement, base low bits rotating
        for (int i = 0; i < 512; i++) begin
            logic [8:0] d;
            d  = 9'(i);
            b  = 64'h8000_0000_0000_0040 - 64'(i % 16);
            ea = b + {{55{d[8]}}, d};
            run_ll(enc_short(5'(i), 5'(i + 3), d, 1'b0), b, 1'b0, 1'b1,
                   (ea[2:0] != 3'd0) ? 2'd2 : 2'd0, ea[2:0] == 3'd0, ea,
                   {32'(i), ~32'(i)}, (i % 3) == 0, (ea[2:0] != 3'd0) ? "R4" : "R2");
        end

        // R1 sweep: strided 16-bit displacements
        for (int k = 0; k < 65536; k += 97) begin
            logic [15:0] d;
            d  = 16'(k);
            b  = 64'h0000_7fff_0001_0000 + 64'((k * 3) % 8);
            ea = b + {{48{d[15]}}, d};
            run_ll(enc_long(5'(k), 5'(k), d), b, 1'b0, 1'b0,
                   (ea[2:0] != 3'd0) ? 2'd2 : 2'd0, ea[2:0] == 3'd0, ea,
                   {~32'(k), 32'(k)}, (k % 2) == 0, (ea[2:0] != 3'd0) ? "R4" : "R1");
        end

        // R3: reserved forms in the newer mode, precedence over alignment
        run_ll(enc_long(5'd1, 5'd2, 16'h0008), 64'h100, 1'b0, 1'b1, 2'd1, 1'b0, 0, 0, 0, "R3");
        run_ll(enc_short(5'd1, 5'd2, 9'h008, 1'b1), 64'h100, 1'b0, 1'b1, 2'd1, 1'b0, 0, 0, 0, "R3");
        run_ll(enc_short(5'd1, 5'd2, 9'h001, 1'b1), 64'h101, 1'b1, 1'b1, 2'd1, 1'b0, 0, 0, 0, "R3");

        // R5: translation fault, and alignment outranks it
        run_ll(enc_long(5'd4, 5'd5, 16'h0010), 64'h2000, 1'b1, 1'b0, 2'd3, 1'b0, 0, 0, 0, "R5");
        run_ll(enc_short(5'd4, 5'd5, 9'h010, 1'b0), 64'h2000, 1'b1, 1'b1, 2'd3, 1'b0, 0, 0, 0, "R5");
        run_ll(enc_long(5'd4, 5'd5, 16'h0013), 64'h2000, 1'b1, 1'b0, 2'd2, 1'b0, 0, 0, 0, "R4");

        // R6: words that match neither layout
        run_ll(32'h0000_0000, 64'h0, 1'b0, 1'b1, 2'd0, 1'b0, 0, 0, 0, "R6");
        run_ll(enc_short(5'd3, 5'd3, 9'h0, 1'b0), 64'h0, 1'b1, 1'b0, 2'd0, 1'b0, 0, 0, 0, "R6");
        run_ll(32'h8c00_0000, 64'h0, 1'b0, 1'b0, 2'd0, 1'b0, 0, 0, 0, "R6");

        // R10: snoop behaviour
        a1 = 64'h0000_1234_5678_9a00;
        run_ll(enc_long(5'd1, 5'd9, 16'h0000), a1, 1'b0, 1'b0, 2'd0, 1'b1, a1, 64'h55, 1'b0, "R8");
        snoop(a1, 1'b0);
        chk(link_bit == 1'b1, "R10", 64'(link_bit), 64'd1);
        snoop(a1 + 64'd8, 1'b1);
        chk(link_bit == 1'b1, "R10", 64'(link_bit), 64'd1);
        snoop(a1 - 64'd1, 1'b1);
        chk(link_bit == 1'b1, "R10", 64'(link_bit), 64'd1);
        snoop(a1 | 64'd5, 1'b1);
        chk(link_bit == 1'b0, "R10", 64'(link_bit), 64'd0);

        // R9: replacement of the reserved address
        a2 = 64'h0000_0000_0000_4000;
        run_ll(enc_long(5'd1, 5'd9, 16'h0000), a1, 1'b0, 1'b0, 2'd0, 1'b1, a1, 64'h1, 1'b0, "R9");
        run_ll(enc_long(5'd1, 5'd9, 16'h0000), a2, 1'b0, 1'b0, 2'd0, 1'b1, a2, 64'h2, 1'b0, "R9");
        snoop(a1, 1'b1);
        chk(link_bit == 1'b1, "R9", 64'(link_bit), 64'd1);
        chk(link_addr == a2, "R9", link_addr, a2);
        snoop(a2 + 64'd7, 1'b1);
        chk(link_bit == 1'b0, "R9", 64'(link_bit), 64'd0);

        // R11: clear strobe, and set winning a same-cycle clear
        run_ll(enc_long(5'd1, 5'd9, 16'h0000), a2, 1'b0, 1'b0, 2'd0, 1'b1, a2, 64'h3, 1'b0, "R11");
        @(negedge clk); sc_clear = 1'b1;
        @(negedge clk); sc_clear = 1'b0;
        chk(link_bit == 1'b0, "R11", 64'(link_bit), 64'd0);
        clr_on_rsp = 1'b1;
        run_ll(enc_long(5'd1, 5'd9, 16'h0000), a1, 1'b0, 1'b0, 2'd0, 1'b1, a1, 64'h4, 1'b1, "R11");
        clr_on_rsp = 1'b0;

        // R12: reservation held across a long idle period
        repeat (1000) @(negedge clk);
        chk(link_bit == 1'b1, "R12", 64'(link_bit), 64'd1);
        chk(link_addr == a1, "R12", link_addr, a1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule